// File: doc/BRIEF.md
# Two-Wire Register-Pointer Slave

This block is a slave on a two-wire serial bus (I2C). A fast system clock samples the bus and the block gives a master access to four 16-bit registers through a 2-bit index pointer. Index 0 returns a live 16-bit sample supplied on an input port and cannot be written. Index 1 holds a configuration word. Indices 2 and 3 hold a lower and an upper limit word. The configuration and limit words drive output ports for the logic around the block.

In a write, the master sends the device address with R/W low. The first data byte then loads the pointer, and each following pair of bytes writes one word, high byte first. In a read, the master sends the device address with R/W high. The block then returns the word the pointer selects, high byte first, until the master answers with a NACK or ends the transfer.

The block also handles four special cases:
- It acknowledges the broadcast address and accepts one command byte, which can clear the interrupt-mode bit.
- It answers a read to address zero with the pointed word.
- It refuses a high-speed master code but remembers it until the next STOP.
- It drops off the bus when SCL stays low for too long.

Top module: `i2cs_top`

## Requirements
- R1: The device answers the 7-bit address {10010, addr_sel}, that is 0x48 to 0x4B, by pulling SDA low during the ninth clock. It leaves a first byte with any other address bits, apart from the special codes in R7 to R9, unacknowledged.
- R2: The first byte after a write address loads bits 1:0 of the pointer. The pointer keeps its value across STOP and START, so a later read without a pointer write returns the same register.
- R3: After the pointer, each pair of bytes writes one word, high byte first, into the pointed register when the low byte completes. Registers 2 and 3 keep bits 3:0 at zero and reset to 0x4B00 and 0x5000.
- R4: The configuration register (index 1) resets to 0x40A0. Only bits 15 and 12:6 take written values, and all its other bits keep their reset value.
- R5: Index 0 reads back the `temp_word` input. A word written to index 0 changes no register.
- R6: A read sends the high byte and then the low byte of the pointed register, each MSB first. After every master ACK the block sends the other byte of the word. After a master NACK it releases SDA and ignores the bus until the next START or STOP. The block changes SDA only while SCL is low, or in reaction to START or STOP.
- R7: The block acknowledges address 0x00 with R/W low (byte 0x00) and the byte after it. If that byte is 0x06, it clears configuration bit 9. It leaves any later byte of that transfer unacknowledged.
- R8: The block acknowledges address 0x00 with R/W high (byte 0x01) and returns the pointed word as in R6. After reset this word is index 0.
- R9: The block does not acknowledge a first byte of the form 00001xxx. Such a byte sets `hs_mode`, which stays high through repeated STARTs and clears only on STOP.
- R10: If SCL stays low for TIMEOUT_CYC system clocks during a transfer, the block releases SDA and ignores the bus until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 2 | Strap that picks the low two bits of the device address |
| temp_word | input | 16 | Live value returned at index 0 |
| sda_drive_low | output | 1 | When high, the pad pulls SDA low |
| hs_mode | output | 1 | A high-speed master code was seen since the last STOP |
| cfg_word | output | 16 | Configuration register |
| low_limit | output | 16 | Lower limit register |
| high_limit | output | 16 | Upper limit register |

## Verification
The assertions check on every cycle that the block changes SDA only while SCL is low or right after START or STOP. They also check that the high-speed flag falls only on STOP, that the pointer moves only on the first data byte of a write, that a timeout releases SDA, and that the configuration changes only through a write to index 1 or the broadcast reset. Only the bench scenarios show the byte-level results: which addresses get an acknowledgment, the byte order and alternation of reads, the write masks, and the pointer surviving STOP. The same holds for the broadcast sequence, the answer at address zero, and the bus being ignored after a timeout.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_RACK,
        S_TX,
        S_MACK,
        S_WAIT
    } phase_e;

    localparam logic [4:0]        ADDR_HI       = 5'b10010;
    localparam logic [4:0]        HS_PREFIX     = 5'b00001;
    localparam logic [BYTE_W-1:0] GC_RESET_CODE = 8'h06;
    localparam logic [WORD_W-1:0] CFG_RESET     = 16'h40A0;
    localparam logic [WORD_W-1:0] CFG_WMASK     = 16'h9FC0;
    localparam logic [WORD_W-1:0] LOW_RESET     = 16'h4B00;
    localparam logic [WORD_W-1:0] HIGH_RESET    = 16'h5000;
    localparam logic [WORD_W-1:0] LIM_WMASK     = 16'hFFF0;
    localparam int                CFG_IM_BIT    = 9;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [1:0] scl_m;
        logic [1:0] sda_m;
        logic       scl_p;
        logic       sda_p;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.scl_m = {s_q.scl_m[0], scl_i};
        s_d.sda_m = {s_q.sda_m[0], sda_i};
        s_d.scl_p = s_q.scl_m[1];
        s_d.sda_p = s_q.sda_m[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_s     = s_q.scl_m[1];
    assign sda_s     = s_q.sda_m[1];
    assign scl_rise  = scl_s & ~s_q.scl_p;
    assign scl_fall  = ~scl_s & s_q.scl_p;
    assign start_det = scl_s & s_q.scl_p & s_q.sda_p & ~sda_s;
    assign stop_det  = scl_s & s_q.scl_p & ~s_q.sda_p & sda_s;
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              gc_clr,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WORD_W-1:0] temp_word,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] cfg_q,
    output logic [WORD_W-1:0] low_q,
    output logic [WORD_W-1:0] high_q
);
    typedef struct packed {
        logic [WORD_W-1:0] cfg;
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (gc_clr) r_d.cfg[CFG_IM_BIT] = 1'b0;
        if (wr_en) begin
            unique case (wr_idx)
                2'd1:    r_d.cfg = (r_q.cfg & ~CFG_WMASK) | (wr_data & CFG_WMASK);
                2'd2:    r_d.lo  = wr_data & LIM_WMASK;
                2'd3:    r_d.hi  = wr_data & LIM_WMASK;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{cfg: CFG_RESET, lo: LOW_RESET, hi: HIGH_RESET};
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (rd_idx)
            2'd0:    rd_data = temp_word;
            2'd1:    rd_data = r_q.cfg;
            2'd2:    rd_data = r_q.lo;
            default: rd_data = r_q.hi;
        endcase
    end

    assign cfg_q  = r_q.cfg;
    assign low_q  = r_q.lo;
    assign high_q = r_q.hi;

    // R4 / R7: configuration moves only through index-1 writes or broadcast reset
    p_cfg_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q != $past(cfg_q)) |-> ($past(wr_en && wr_idx == 2'd1) || $past(gc_clr)));

    // R5: a write at index 0 leaves every stored word unchanged
    p_idx0_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 2'd0) |=> ($stable(cfg_q) && $stable(low_q) && $stable(high_q)));
endmodule

// File: rtl/i2cs_proto.sv
module i2cs_proto
    import i2cs_pkg::*;
#(
    parameter int TIMEOUT_CYC = 7_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        addr_sel,
    input  logic [WORD_W-1:0] rd_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WORD_W-1:0] wr_data,
    output logic              gc_clr,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              sda_drive_low,
    output logic              hs_mode
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        phase_e            ph;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic              first;
        logic              rw;
        logic              gc;
        logic [1:0]        nbyte;
        logic [IDX_W-1:0]  ptr;
        logic [BYTE_W-1:0] msb;
        logic              hs;
        logic              lsb_sent;
        logic              nack;
        logic [TW-1:0]     tmo;
    } st_t;

    st_t q, n;

    always_comb begin
        n       = q;
        wr_en   = 1'b0;
        gc_clr  = 1'b0;
        wr_data = {q.msb, q.sh};
        if (scl_s || q.ph == S_IDLE)            n.tmo = '0;
        else if (q.tmo != TW'(TIMEOUT_CYC))     n.tmo = q.tmo + TW'(1);

        if (start_det) begin
            n.ph = S_RX; n.cnt = '0; n.first = 1'b1; n.gc = 1'b0; n.nbyte = '0;
        end else if (stop_det) begin
            n.ph = S_IDLE; n.hs = 1'b0;
        end else if (q.tmo == TW'(TIMEOUT_CYC)) begin
            n.ph = S_IDLE; n.tmo = '0;
        end else begin
            unique case (q.ph)
                S_RX: begin
                    if (scl_rise) begin
                        n.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        n.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        n.cnt = '0;
                        if (q.first) begin
                            n.first = 1'b0;
                            n.rw    = q.sh[0];
                            if (q.sh[7:1] == {ADDR_HI, addr_sel}) begin
                                n.ph = S_RACK;
                            end else if (q.sh[7:1] == 7'd0) begin
                                n.ph = S_RACK;
                                n.gc = ~q.sh[0];
                            end else begin
                                n.ph = S_WAIT;
                                if (q.sh[7:3] == HS_PREFIX) n.hs = 1'b1;
                            end
                        end else if (q.gc) begin
                            if (q.nbyte == 2'd0) begin
                                n.ph    = S_RACK;
                                n.nbyte = 2'd1;
                                gc_clr  = (q.sh == GC_RESET_CODE);
                            end else begin
                                n.ph = S_WAIT;
                            end
                        end else begin
                            n.ph = S_RACK;
                            if (q.nbyte == 2'd0) begin
                                n.ptr   = q.sh[IDX_W-1:0];
                                n.nbyte = 2'd1;
                            end else if (q.nbyte == 2'd1) begin
                                n.msb   = q.sh;
                                n.nbyte = 2'd2;
                            end else begin
                                wr_en   = 1'b1;
                                n.nbyte = 2'd1;
                            end
                        end
                    end
                end
                S_RACK: begin
                    if (scl_fall) begin
                        n.cnt = '0;
                        if (q.rw) begin
                            n.ph       = S_TX;
                            n.sh       = rd_data[WORD_W-1:BYTE_W];
                            n.lsb_sent = 1'b0;
                        end else begin
                            n.ph = S_RX;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            n.ph = S_MACK;
                        end else begin
                            n.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            n.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        n.nack = sda_s;
                    end else if (scl_fall) begin
                        if (q.nack) begin
                            n.ph = S_WAIT;
                        end else begin
                            n.ph       = S_TX;
                            n.cnt      = '0;
                            n.sh       = q.lsb_sent ? rd_data[WORD_W-1:BYTE_W] : rd_data[BYTE_W-1:0];
                            n.lsb_sent = ~q.lsb_sent;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: S_IDLE, default: '0};
        else        q <= n;
    end

    assign wr_idx        = q.ptr;
    assign rd_idx        = q.ptr;
    assign hs_mode       = q.hs;
    assign sda_drive_low = (q.ph == S_RACK) || (q.ph == S_TX && !q.sh[BYTE_W-1]);

    // R6: SDA changes only while SCL is low, apart from reactions to START/STOP
    p_drive_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low != $past(sda_drive_low)) |-> (!scl_s || $past(start_det) || $past(stop_det)));

    // R9: the high-speed flag clears only on STOP
    p_hs_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_mode) |-> $past(stop_det));

    // R2: the pointer moves only on the first data byte of a write
    p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ptr != $past(q.ptr)) |-> $past(q.ph == S_RX && !q.first && !q.gc && q.nbyte == 2'd0));

    // R10: an expired low-SCL window releases SDA
    p_timeout_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_s && q.tmo == TW'(TIMEOUT_CYC)) |=> !sda_drive_low);
endmodule

// File: rtl/i2cs_top.sv
module i2cs_top
    import i2cs_pkg::*;
#(
    parameter int TIMEOUT_CYC = 7_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        addr_sel,
    input  logic [WORD_W-1:0] temp_word,
    output logic              sda_drive_low,
    output logic              hs_mode,
    output logic [WORD_W-1:0] cfg_word,
    output logic [WORD_W-1:0] low_limit,
    output logic [WORD_W-1:0] high_limit
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en, gc_clr;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [WORD_W-1:0] wr_data, rd_data;

    i2cs_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cs_proto #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_proto (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .addr_sel(addr_sel), .rd_data(rd_data), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .gc_clr(gc_clr), .rd_idx(rd_idx),
        .sda_drive_low(sda_drive_low), .hs_mode(hs_mode)
    );

    i2cs_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .gc_clr(gc_clr), .rd_idx(rd_idx), .temp_word(temp_word), .rd_data(rd_data),
        .cfg_q(cfg_word), .low_q(low_limit), .high_q(high_limit)
    );
endmodule

// File: tb/i2cs_top_tb.sv
module i2cs_top_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TMO = 300;
    localparam time QT = 40ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic [1:0]  addr_sel = 2'd0;
    logic [15:0] temp_word = 16'h1900;
    logic        sda_drive_low, hs_mode;
    logic [15:0] cfg_word, low_limit, high_limit;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;

    logic [15:0] exp_q[$];
    logic [15:0] act_q[$];
    string       tag_q[$];
    event        got;

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_drive_low;

    i2cs_top #(.TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel(addr_sel), .temp_word(temp_word), .sda_drive_low(sda_drive_low),
        .hs_mode(hs_mode), .cfg_word(cfg_word), .low_limit(low_limit), .high_limit(high_limit)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items as the bus produces results
    initial begin
        forever begin
            @(got);
            while (act_q.size() > 0) begin
                if (exp_q.size() == 0) begin
                    check(act_q.pop_front(), 16'hxxxx, "scoreboard underflow");
                end else begin
                    check(act_q.pop_front(), exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    task automatic bus_start();
        sda_m = 1'b1; #QT; scl_m = 1'b1; #QT; sda_m = 1'b0; #QT; scl_m = 1'b0; #QT;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; #QT; scl_m = 1'b1; #QT; sda_m = 1'b1; #QT;
    endtask

    // driver: send a byte, scoreboard its acknowledge (1 = acked)
    task automatic wr(input logic [7:0] b, input logic exp_ack, input string tag);
        logic ack;
        exp_q.push_back({15'd0, exp_ack}); tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; #QT; scl_m = 1'b1; #QT; #QT; scl_m = 1'b0; #QT;
        end
        sda_m = 1'b1; #QT; scl_m = 1'b1; #QT; ack = ~sda_line; #QT; scl_m = 1'b0; #QT;
        act_q.push_back({15'd0, ack}); -> got;
    endtask

    // driver: receive a byte, answer with ACK (nack=0) or NACK (nack=1)
    task automatic rd(input logic nack, input logic [7:0] exp_b, input string tag);
        logic [7:0] b;
        exp_q.push_back({8'd0, exp_b}); tag_q.push_back(tag);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            #QT; scl_m = 1'b1; #QT; b[i] = sda_line; #QT; scl_m = 1'b0;
        end
        #QT; sda_m = nack; #QT; scl_m = 1'b1; #QT; #QT; scl_m = 1'b0; #QT; sda_m = 1'b1;
        act_q.push_back({8'd0, b}); -> got;
    endtask

    initial begin
        #21 rst_n = 1'b1;
        #80;
        // reset state
        check({15'd0, sda_drive_low}, 16'd0, "R6 reset SDA released");
        check({15'd0, hs_mode}, 16'd0, "R9 reset hs flag");
        check(cfg_word, 16'h40A0, "R4 cfg reset");
        check(low_limit, 16'h4B00, "R3 low reset");
        check(high_limit, 16'h5000, "R3 high reset");

        // R8: start-byte read after reset returns index 0
        bus_start(); wr(8'h01, 1'b1, "R8 start byte ack");
        rd(1'b0, 8'h19, "R8 start byte msb"); rd(1'b1, 8'h00, "R8 start byte lsb"); bus_stop();

        // R1: foreign address
        bus_start(); wr(8'hA0, 1'b0, "R1 foreign address nack"); bus_stop();

        // R3: write limit word
        bus_start(); wr(8'h90, 1'b1, "R1 own address ack"); wr(8'h02, 1'b1, "R2 pointer ack");
        wr(8'h12, 1'b1, "R3 msb ack"); wr(8'h34, 1'b1, "R3 lsb ack"); bus_stop();
        check(low_limit, 16'h1230, "R3 low written nibble cleared");

        // R2/R6: read without a new pointer
        bus_start(); wr(8'h91, 1'b1, "R1 read address ack");
        rd(1'b0, 8'h12, "R2 pointer kept msb"); rd(1'b1, 8'h30, "R6 lsb"); bus_stop();

        // R6: MSB-only read
        bus_start(); wr(8'h91, 1'b1, "R6 read address ack"); rd(1'b1, 8'h12, "R6 msb only");
        check({15'd0, sda_drive_low}, 16'd0, "R6 released after nack");
        bus_stop();

        // R4: configuration masks
        bus_start(); wr(8'h90, 1'b1, "R4 addr"); wr(8'h01, 1'b1, "R4 ptr");
        wr(8'hFF, 1'b1, "R4 msb"); wr(8'hFF, 1'b1, "R4 lsb"); bus_stop();
        check(cfg_word, 16'hDFE0, "R4 cfg all ones");
        bus_start(); wr(8'h90, 1'b1, "R4 addr"); wr(8'h01, 1'b1, "R4 ptr");
        wr(8'h02, 1'b1, "R4 msb"); wr(8'h00, 1'b1, "R4 lsb"); bus_stop();
        check(cfg_word, 16'h4220, "R4 cfg read-only bits kept");

        // R7: broadcast reset
        bus_start(); wr(8'h00, 1'b1, "R7 broadcast ack"); wr(8'h06, 1'b1, "R7 second byte ack");
        wr(8'h55, 1'b0, "R7 third byte nack"); bus_stop();
        check(cfg_word, 16'h4020, "R7 im bit cleared");

        // R5: index 0 ignores writes
        bus_start(); wr(8'h90, 1'b1, "R5 addr"); wr(8'h00, 1'b1, "R5 ptr");
        wr(8'hAB, 1'b1, "R5 msb"); wr(8'hCD, 1'b1, "R5 lsb"); bus_stop();
        check(cfg_word, 16'h4020, "R5 cfg untouched");
        check(low_limit, 16'h1230, "R5 low untouched");
        check(high_limit, 16'h5000, "R5 high untouched");
        bus_start(); wr(8'h91, 1'b1, "R5 read addr");
        rd(1'b0, 8'h19, "R5 temp msb"); rd(1'b1, 8'h00, "R5 temp lsb"); bus_stop();

        // R8/R6: start byte after pointing at index 3, alternating bytes
        bus_start(); wr(8'h90, 1'b1, "R8 addr"); wr(8'h03, 1'b1, "R8 ptr"); bus_stop();
        bus_start(); wr(8'h01, 1'b1, "R8 start byte ack");
        rd(1'b0, 8'h50, "R8 last pointed msb"); rd(1'b0, 8'h00, "R8 last pointed lsb");
        rd(1'b1, 8'h50, "R6 alternates to msb"); bus_stop();

        // R1: strap selects 0x4B
        addr_sel = 2'd3;
        bus_start(); wr(8'h90, 1'b0, "R1 0x48 refused with strap 3"); bus_stop();
        bus_start(); wr(8'h96, 1'b1, "R1 0x4B ack"); wr(8'h03, 1'b1, "R1 ptr"); bus_stop();

        // R9: high-speed code
        bus_start(); wr(8'h09, 1'b0, "R9 hs code nack");
        check({15'd0, hs_mode}, 16'd1, "R9 hs set");
        bus_start(); wr(8'h96, 1'b1, "R9 address after hs");
        check({15'd0, hs_mode}, 16'd1, "R9 hs kept over restart");
        bus_stop();
        check({15'd0, hs_mode}, 16'd0, "R9 hs cleared by stop");

        // R10: timeout while driving a zero bit
        bus_start(); wr(8'h97, 1'b1, "R10 read addr");
        check({15'd0, sda_drive_low}, 16'd1, "R10 driving before timeout");
        #((TMO + 60) * 4);
        check({15'd0, sda_drive_low}, 16'd0, "R10 released after timeout");
        wr(8'h96, 1'b0, "R10 ignored until start");
        bus_stop();
        bus_start(); wr(8'h96, 1'b1, "R10 recovers on start"); bus_stop();

        #200;
        -> got;
        #10;
        check(exp_q.size(), 16'd0, "scoreboard drained");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #600us;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule